// File: doc/BRIEF.md
# Mailbox command dispatcher

This block owns a 64-byte mailbox that a host reads and writes one byte at a time. The last byte of the mailbox is a command register, and each bit in it is a separate request. When the host sets one or more request bits, the block services them one after another. It can start a frame parse in a neighbouring block, mark boot as finished, lock the boot ROM, latch and clear a checksum held in the mailbox, or compare that checksum against an expected value. When a request has been carried out, the block clears its bit.

A boot watchdog starts counting when reset is released. If the boot-complete request has not arrived within a set number of cycles, the block raises a sticky halt request. A checksum compare that fails raises the same halt. Once halt is raised, the block starts no further requests.

Top module: `mbox_cmd_dispatch`

## Requirements
- R1: After reset, `rom_lock`, `reset_enable`, `halt_req` and `parse_start` are all 0, and the command byte (address 0x3F) reads 0.
- R2: A host write to any address stores the byte. A host read returns the stored byte one clock after the address is presented. Address 0x3F reads back the command register.
- R3: Command bit 0 produces exactly one single-cycle `parse_start` pulse. The bit stays set until `parse_done` is seen, and is cleared afterwards.
- R4: Command bit 3 sets `reset_enable`, which stays set until reset. It stops the boot watchdog and clears bit 3.
- R5: Command bit 4 sets `rom_lock`, which stays set until reset, and clears bit 4.
- R6: Command bit 5 copies mailbox bytes 0x32 to 0x37 into an internal 48-bit checksum, with byte 0x32 as the most significant byte. It writes 0 to those six bytes and leaves all other bytes unchanged. It then clears bit 5 and sets bit 7 as the acknowledge.
- R7: Command bit 6 compares the latched checksum (0 after reset) with `expect_sum`. On a mismatch it raises `halt_req`. Bit 6 is cleared whether or not the values match.
- R8: Command bit 2 is ignored and stays as written. Bit 7 is not a request: writing it alone changes no output and leaves the byte as written.
- R9: When several request bits are set, they are serviced lowest bit first, one at a time. A later request does not start until the earlier one has completed, so bit 4 waits for a pending parse.
- R10: If bit 3 has not been serviced, `halt_req` rises BOOT_TIMEOUT+1 clocks after reset is released. If bit 3 is serviced before then, `halt_req` never rises from the watchdog.
- R11: `halt_req` stays set until reset. While it is set, no new request is serviced and the request bits stay as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one clock after the address |
| expect_sum | input | 48 | Expected checksum supplied at boot |
| parse_start | output | 1 | One-cycle request to the frame parser |
| parse_done | input | 1 | Frame parser completion |
| rom_lock | output | 1 | Boot ROM locked against host reads |
| reset_enable | output | 1 | Reset button enabled after boot completes |
| halt_req | output | 1 | Sticky halt request to the host processor |

## Verification
Most of the internal state can be read directly or shows up on an output within a few cycles:
- A sequencer stuck outside idle shows up as request bits that never clear. The command byte read at 0x3F exposes this well within the 60-cycle settle window the bench uses.
- A wrong byte index or shift direction during the checksum latch shows up two ways. Some bytes in 0x32 to 0x37 read back nonzero, and a later compare against the true value raises `halt_req`.
- A wrong priority shows up as `rom_lock` rising while a parse request is still pending.
- A watchdog that counts wrongly shows up as `halt_req` moving outside the window around BOOT_TIMEOUT.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Positions of the request bits in the command byte
  localparam int unsigned CB_PARSE = 0;
  localparam int unsigned CB_SPARE = 2;
  localparam int unsigned CB_BOOT  = 3;
  localparam int unsigned CB_LOCK  = 4;
  localparam int unsigned CB_LATCH = 5;
  localparam int unsigned CB_CHECK = 6;
  localparam int unsigned CB_ACK   = 7;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PARSE = 2'd1,
    SQ_RD    = 2'd2,
    SQ_WR    = 2'd3
  } seq_state_t;

endpackage

// File: rtl/mbox_ram.sv
module mbox_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Both ports read before write. If both ports write the same
  // address in one cycle, the host port (a) wins.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/mbox_boot_wdog.sv
module mbox_boot_wdog #(
  parameter int unsigned LIMIT = 80_000_000,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic boot_done,
  output logic expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else if (!boot_done && !expired) begin
      if (cnt_q == CW'(LIMIT - 1)) expired <= 1'b1;
      else                         cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_pkg::*;
#(
  parameter int unsigned AW        = 6,
  parameter int unsigned DW        = 8,
  parameter int unsigned SUM_OFS   = 'h32,
  parameter int unsigned SUM_BYTES = 6,
  localparam int unsigned SW       = SUM_BYTES * DW,
  localparam int unsigned IW       = $clog2(SUM_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    req,          // {check, latch, lock, boot, parse}
  input  logic          halted,
  input  logic [SW-1:0] expect_sum,
  input  logic          parse_done,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] cmd_clr,
  output logic [DW-1:0] cmd_set,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          parse_start,
  output logic          boot_done,
  output logic          rom_lock,
  output logic          sum_bad
);

  seq_state_t    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [SW-1:0] sum_q, sum_d;
  logic          start_d, done_d, lock_d;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    sum_d     = sum_q;
    start_d   = 1'b0;
    done_d    = boot_done;
    lock_d    = rom_lock;
    cmd_clr   = '0;
    cmd_set   = '0;
    ram_we    = 1'b0;
    ram_addr  = AW'(SUM_OFS) + AW'(idx_q);
    ram_wdata = '0;
    sum_bad   = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (!halted) begin
          if (req[0]) begin
            state_d = SQ_PARSE;
            start_d = 1'b1;
          end else if (req[1]) begin
            done_d           = 1'b1;
            cmd_clr[CB_BOOT] = 1'b1;
          end else if (req[2]) begin
            lock_d           = 1'b1;
            cmd_clr[CB_LOCK] = 1'b1;
          end else if (req[3]) begin
            state_d = SQ_RD;
            idx_d   = '0;
          end else if (req[4]) begin
            cmd_clr[CB_CHECK] = 1'b1;
            sum_bad           = (sum_q != expect_sum);
          end
        end
      end
      SQ_PARSE: begin
        if (parse_done) begin
          cmd_clr[CB_PARSE] = 1'b1;
          state_d           = SQ_IDLE;
        end
      end
      SQ_RD: begin
        state_d = SQ_WR;
      end
      SQ_WR: begin
        sum_d  = {sum_q[SW-DW-1:0], ram_rdata};
        ram_we = 1'b1;
        if (idx_q == IW'(SUM_BYTES - 1)) begin
          cmd_clr[CB_LATCH] = 1'b1;
          cmd_set[CB_ACK]   = 1'b1;
          state_d           = SQ_IDLE;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = SQ_RD;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      idx_q       <= '0;
      sum_q       <= '0;
      parse_start <= 1'b0;
      boot_done   <= 1'b0;
      rom_lock    <= 1'b0;
    end else begin
      state_q     <= state_d;
      idx_q       <= idx_d;
      sum_q       <= sum_d;
      parse_start <= start_d;
      boot_done   <= done_d;
      rom_lock    <= lock_d;
    end
  end

endmodule

// File: rtl/mbox_cmd_dispatch.sv
module mbox_cmd_dispatch
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH        = 64,
  parameter int unsigned DW           = 8,
  parameter int unsigned SUM_OFS      = 'h32,
  parameter int unsigned SUM_BYTES    = 6,
  parameter int unsigned BOOT_TIMEOUT = 80_000_000,
  localparam int unsigned AW          = $clog2(DEPTH),
  localparam int unsigned SW          = SUM_BYTES * DW,
  localparam int unsigned CMD_ADDR    = DEPTH - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [SW-1:0] expect_sum,
  output logic          parse_start,
  input  logic          parse_done,
  output logic          rom_lock,
  output logic          reset_enable,
  output logic          halt_req
);

  logic [DW-1:0] cmd_q, cmd_snap_q, cmd_clr, cmd_set;
  logic          rd_cmd_q, host_cmd_wr;
  logic [DW-1:0] ram_a_rdata, ram_b_rdata, ram_b_wdata;
  logic [AW-1:0] ram_b_addr;
  logic          ram_b_we, wd_expired, sum_bad;
  logic [4:0]    req;

  assign host_cmd_wr = host_we && (host_addr == AW'(CMD_ADDR));
  assign req = {cmd_q[CB_CHECK], cmd_q[CB_LATCH], cmd_q[CB_LOCK],
                cmd_q[CB_BOOT], cmd_q[CB_PARSE]};

  mbox_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk     (clk),
    .a_we    (host_we),
    .a_addr  (host_addr),
    .a_wdata (host_wdata),
    .a_rdata (ram_a_rdata),
    .b_we    (ram_b_we),
    .b_addr  (ram_b_addr),
    .b_wdata (ram_b_wdata),
    .b_rdata (ram_b_rdata)
  );

  mbox_cmd_seq #(
    .AW(AW), .DW(DW), .SUM_OFS(SUM_OFS), .SUM_BYTES(SUM_BYTES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .halted      (halt_req),
    .expect_sum  (expect_sum),
    .parse_done  (parse_done),
    .ram_rdata   (ram_b_rdata),
    .cmd_clr     (cmd_clr),
    .cmd_set     (cmd_set),
    .ram_we      (ram_b_we),
    .ram_addr    (ram_b_addr),
    .ram_wdata   (ram_b_wdata),
    .parse_start (parse_start),
    .boot_done   (reset_enable),
    .rom_lock    (rom_lock),
    .sum_bad     (sum_bad)
  );

  mbox_boot_wdog #(.LIMIT(BOOT_TIMEOUT)) u_wdog (
    .clk       (clk),
    .rst       (rst),
    .boot_done (reset_enable),
    .expired   (wd_expired)
  );

  // Command register: a host write wins over the sequencer's update
  always_ff @(posedge clk) begin
    if (rst)              cmd_q <= '0;
    else if (host_cmd_wr) cmd_q <= host_wdata;
    else                  cmd_q <= (cmd_q & ~cmd_clr) | cmd_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cmd_q   <= 1'b0;
      cmd_snap_q <= '0;
      halt_req   <= 1'b0;
    end else begin
      rd_cmd_q   <= (host_addr == AW'(CMD_ADDR));
      cmd_snap_q <= cmd_q;
      halt_req   <= halt_req | wd_expired | sum_bad;
    end
  end

  assign host_rdata = rd_cmd_q ? cmd_snap_q : ram_a_rdata;

endmodule

// File: rtl/mbox_cmd_chk.sv
module mbox_cmd_chk #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] cmd_q,
  input logic          parse_start,
  input logic          rom_lock,
  input logic          reset_enable,
  input logic          halt_req
);

  logic hw_cmd;
  assign hw_cmd = host_we && (host_addr == '1);

  // R3: the parse request is a single-cycle pulse
  p_parse_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    parse_start |=> !parse_start);

  // R4: reset enable is sticky
  p_renable_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    reset_enable |=> reset_enable);

  // R5: ROM lock is sticky
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    rom_lock |=> rom_lock);

  // R6: the acknowledge bit only appears by a host write or at the end of a latch
  p_ack_src_r6: assert property (@(posedge clk) disable iff (rst)
    (!hw_cmd && !cmd_q[7]) |=> (!cmd_q[7] || $past(cmd_q[5])));

  // R8: the spare bit is never touched by the block
  p_spare_kept_r8: assert property (@(posedge clk) disable iff (rst)
    !hw_cmd |=> $stable(cmd_q[2]));

  // R9: at most one request action starts in any cycle
  p_one_action_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({parse_start, $rose(rom_lock), $rose(reset_enable)}));

  // R11: halt is sticky
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> halt_req);

  // R11: while halted, request bits only change by host writes
  p_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    (halt_req && $past(halt_req) && !hw_cmd) |=> $stable(cmd_q));

endmodule

bind mbox_cmd_dispatch mbox_cmd_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_we      (host_we),
  .host_addr    (host_addr),
  .cmd_q        (cmd_q),
  .parse_start  (parse_start),
  .rom_lock     (rom_lock),
  .reset_enable (reset_enable),
  .halt_req     (halt_req)
);

// File: tb/test_mbox_cmd_dispatch.sv
module test_mbox_cmd_dispatch;

  localparam int unsigned TMO = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [47:0] expect_sum = '0;
  logic        parse_start;
  logic        parse_done = 1'b0;
  logic        rom_lock, reset_enable, halt_req;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int resp_dly = 3;

  always #2 clk = ~clk;

  mbox_cmd_dispatch #(.BOOT_TIMEOUT(TMO)) i_mbox_cmd_dispatch (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .expect_sum(expect_sum),
    .parse_start(parse_start), .parse_done(parse_done), .rom_lock(rom_lock),
    .reset_enable(reset_enable), .halt_req(halt_req)
  );

  typedef struct packed {
    logic [7:0]  cmd;
    logic [47:0] sum;
    logic [47:0] exp;
    logic [7:0]  cmd_after;
    logic        lock;
    logic        ren;
    logic        halt;
  } vec_t;

  localparam logic [47:0] S_OK  = 48'h3C5A_9617_E2D4;
  localparam logic [47:0] S_BAD = 48'h3C5A_9617_E2D5;

  localparam vec_t VECS [9] = '{
    '{8'h08, 48'h0, 48'h0, 8'h00, 1'b0, 1'b1, 1'b0},  // R4
    '{8'h10, 48'h0, 48'h0, 8'h00, 1'b1, 1'b0, 1'b0},  // R5
    '{8'h04, 48'h0, 48'h0, 8'h04, 1'b0, 1'b0, 1'b0},  // R8
    '{8'h20, S_OK,  48'h0, 8'h80, 1'b0, 1'b0, 1'b0},  // R6
    '{8'h60, S_OK,  S_OK,  8'h80, 1'b0, 1'b0, 1'b0},  // R7 match
    '{8'h60, S_OK,  S_BAD, 8'h80, 1'b0, 1'b0, 1'b1},  // R7 mismatch
    '{8'h19, 48'h0, 48'h0, 8'h00, 1'b1, 1'b1, 1'b0},  // R3 with R9
    '{8'h7D, S_OK,  S_OK,  8'h84, 1'b1, 1'b1, 1'b0},  // R9 all bits
    '{8'h40, 48'h0, 48'h0, 8'h00, 1'b0, 1'b0, 1'b0}   // R7 reset value
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R4";
      1: return "R5";
      2: return "R8";
      3: return "R6";
      4, 5, 8: return "R7";
      6: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    host_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic host_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    host_we = 1'b0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic load_sum(input logic [47:0] s);
    for (int b = 0; b < 6; b++) host_wr(6'(8'h32 + b), s[47 - 8*b -: 8]);
  endtask

  // Frame parser model
  initial begin
    forever begin
      @(negedge clk);
      if (parse_start) begin
        pulses++;
        repeat (resp_dly) @(negedge clk);
        parse_done = 1'b1;
        @(negedge clk);
        parse_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;

    // R1: reset state
    do_reset();
    @(negedge clk);
    chk(!rom_lock && !reset_enable && !halt_req && !parse_start, "R1",
        "outputs after reset", {rom_lock, reset_enable, halt_req, parse_start}, 0);
    host_rd(6'h3F, rd);
    chk(rd == 8'h00, "R1", "command byte after reset", rd, 0);

    // R2: plain storage and readback
    host_wr(6'h10, 8'h5C);
    host_wr(6'h3E, 8'hA7);
    host_rd(6'h10, rd);
    chk(rd == 8'h5C, "R2", "byte 0x10", rd, 8'h5C);
    host_rd(6'h3E, rd);
    chk(rd == 8'hA7, "R2", "byte 0x3E", rd, 8'hA7);

    // Vector table
    for (int i = 0; i < 9; i++) begin
      do_reset();
      pulses = 0;
      expect_sum = VECS[i].exp;
      load_sum(VECS[i].sum);
      host_wr(6'h3F, VECS[i].cmd);
      repeat (60) @(negedge clk);
      host_rd(6'h3F, rd);
      chk(rd == VECS[i].cmd_after, vtag(i), $sformatf("vec %0d cmd byte", i),
          rd, VECS[i].cmd_after);
      chk({rom_lock, reset_enable, halt_req} ==
          {VECS[i].lock, VECS[i].ren, VECS[i].halt}, vtag(i),
          $sformatf("vec %0d lock/ren/halt", i),
          {rom_lock, reset_enable, halt_req},
          {VECS[i].lock, VECS[i].ren, VECS[i].halt});
      chk(pulses == int'(VECS[i].cmd[0]), "R3", $sformatf("vec %0d parse pulses", i),
          pulses, VECS[i].cmd[0]);
    end

    // R6: latched bytes zeroed, neighbours kept
    do_reset();
    host_wr(6'h31, 8'h11);
    host_wr(6'h38, 8'h22);
    load_sum(S_OK);
    host_wr(6'h3F, 8'h20);
    repeat (30) @(negedge clk);
    for (int b = 0; b < 6; b++) begin
      host_rd(6'(8'h32 + b), rd);
      chk(rd == 8'h00, "R6", $sformatf("byte %0h zeroed", 8'h32 + b), rd, 0);
    end
    host_rd(6'h31, rd);
    chk(rd == 8'h11, "R6", "byte 0x31 kept", rd, 8'h11);
    host_rd(6'h38, rd);
    chk(rd == 8'h22, "R6", "byte 0x38 kept", rd, 8'h22);

    // R9: lock waits for a slow parse
    do_reset();
    resp_dly = 30;
    host_wr(6'h3F, 8'h11);
    repeat (10) @(negedge clk);
    chk(!rom_lock, "R9", "lock during pending parse", rom_lock, 0);
    host_rd(6'h3F, rd);
    chk(rd == 8'h11, "R9", "both bits pending", rd, 8'h11);
    repeat (50) @(negedge clk);
    chk(rom_lock, "R9", "lock after parse", rom_lock, 1);
    host_rd(6'h3F, rd);
    chk(rd == 8'h00, "R3", "bit 0 cleared after done", rd, 0);
    resp_dly = 3;

    // R8: acknowledge bit alone is not a request
    do_reset();
    host_wr(6'h3F, 8'h80);
    repeat (20) @(negedge clk);
    host_rd(6'h3F, rd);
    chk(rd == 8'h80 && !rom_lock && !reset_enable && !halt_req, "R8",
        "bit 7 alone", {rd, rom_lock, reset_enable, halt_req}, {8'h80, 3'b000});

    // R10: watchdog expiry window
    do_reset();
    repeat (TMO - 40) @(negedge clk);
    chk(!halt_req, "R10", "halt before timeout", halt_req, 0);
    repeat (80) @(negedge clk);
    chk(halt_req, "R10", "halt after timeout", halt_req, 1);

    // R10 with R4: boot-complete stops the watchdog
    do_reset();
    host_wr(6'h3F, 8'h08);
    repeat (TMO + 100) @(negedge clk);
    chk(!halt_req && reset_enable, "R10", "no halt after boot done",
        {halt_req, reset_enable}, 2'b01);

    // R11: halted block services nothing
    do_reset();
    expect_sum = S_BAD;
    load_sum(S_OK);
    host_wr(6'h3F, 8'h60);
    repeat (30) @(negedge clk);
    chk(halt_req, "R11", "halt on mismatch", halt_req, 1);
    host_wr(6'h3F, 8'h10);
    repeat (20) @(negedge clk);
    host_rd(6'h3F, rd);
    chk(rd == 8'h10 && !rom_lock && halt_req, "R11", "frozen after halt",
        {rd, rom_lock, halt_req}, {8'h10, 2'b01});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule